// File: doc/BRIEF.md
# Segment Access Protection Checker

This block validates a single memory reference against a segment descriptor that is already held in registers next to it. Each request presents the descriptor's rights byte, its 24-bit base and 16-bit limit, together with the 16-bit offset being referenced, the kind of reference and the privilege level of the running code. One clock later the block reports whether the reference is granted. When it is granted, the block also returns the 24-bit physical address and the rights byte with its accessed flag set, ready to be written back to the descriptor cache.

A refused reference gets a three-bit fault code. Present, segment class, code or data kind, the meaning of bits 2 and 1, and the descriptor privilege level are all decoded from the rights byte. Bits 2 and 1 mean different things for code segments and for data segments. Data segments may grow downward, and this inverts the limit test. Descriptor table walks, gates and task switches are handled elsewhere.

Top module: `seg_prot_chk`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, grant_o, fault_o, fault_code_o, paddr_o and rights_o are all zero until the first request is taken.
- R2: A request sampled with req_i high at a rising edge gives valid_o high for exactly the following cycle. In that cycle exactly one of grant_o and fault_o is high. With no request, valid_o, grant_o and fault_o are low.
- R3: Rights byte bit 7 is the present flag. When it is 0, the fault code is 1 (not present), whatever else applies.
- R4: Bit 4 = 0 marks a system descriptor. A reference to it gives fault code 2 (type). kind_i = 3 is reserved and also gives code 2.
- R5: A code segment has bit 3 = 1, and kind_i encodes 0 = read, 1 = write, 2 = execute. On a code segment, execute is allowed, write gives code 2, and read gives code 2 unless bit 1 (readable) is 1.
- R6: A data segment has bit 3 = 0. On a data segment, read is allowed, execute gives code 2, and write gives code 2 unless bit 1 (writable) is 1.
- R7: Code segments and data segments with bit 2 = 0 fault with code 3 (limit) when offset_i > limit_i.
- R8: Data segments with bit 2 = 1 grow downward and fault with code 3 when offset_i <= limit_i.
- R9: When cpl_i is greater than the descriptor privilege level in bits 6:5, the fault code is 4 (privilege). The exception is a code segment with bit 2 = 1 (conforming), which skips this check.
- R10: Fault code 0 means granted. When more than one fault applies, the reported code is the first in the order not present, type, limit, privilege.
- R11: On a grant, paddr_o = (base_i + offset_i) mod 2^24, with the offset zero-extended. On a fault, paddr_o = 0.
- R12: On a grant, rights_o is rights_i with bit 0 set. On a fault, rights_o equals rights_i unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Check request strobe |
| rights_i | input | 8 | Descriptor rights byte |
| base_i | input | 24 | Segment base |
| limit_i | input | 16 | Segment limit |
| offset_i | input | 16 | Referenced offset |
| kind_i | input | 2 | Reference kind: 0 read, 1 write, 2 execute, 3 reserved |
| cpl_i | input | 2 | Current privilege level |
| valid_o | output | 1 | Result valid, one cycle after request |
| grant_o | output | 1 | Reference allowed |
| fault_o | output | 1 | Reference refused |
| fault_code_o | output | 3 | 0 none, 1 not present, 2 type, 3 limit, 4 privilege |
| paddr_o | output | 24 | Physical address on grant |
| rights_o | output | 8 | Rights byte to write back |

## Verification
The bench sweeps every rights byte against every reference kind and every privilege level. Each of these combinations is run with offsets just below, at and just above the limit. This catches a design that reads bits 2 and 1 the same way for code and data, since it would let writes through to readable code or refuse growing-down data inside its valid range. It also catches an off-by-one in either limit comparison, which would grant or refuse the offset equal to the limit on the wrong side. A wrong priority order would show up as, for example, a limit code on a segment that is not present. Separate cases cover a full 64 KiB limit, a base that wraps past 2^24, and the accessed flag being left clear on a grant or set on a fault.

// File: rtl/seg_prot_pkg.sv
package seg_prot_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_NPRES = 3'd1,
    FLT_TYPE  = 3'd2,
    FLT_LIMIT = 3'd3,
    FLT_PRIV  = 3'd4
  } flt_code_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       is_seg;
    logic       is_code;
    logic       dir_conf;  // data: grows down, code: conforming
    logic       rd_wr;     // data: writable, code: readable
    logic       accessed;
  } rights_t;

endpackage

// File: rtl/seg_rights_dec.sv
module seg_rights_dec
  import seg_prot_pkg::*;
(
  input  logic [7:0] rights_i,
  input  logic [1:0] kind_i,
  output rights_t    dec_o,
  output logic       type_ok_o,
  output logic       expand_dn_o,
  output logic       conforming_o
);

  acc_kind_e kind;

  always_comb begin
    dec_o        = rights_t'(rights_i);
    kind         = acc_kind_e'(kind_i);
    expand_dn_o  = !dec_o.is_code && dec_o.dir_conf;
    conforming_o = dec_o.is_code && dec_o.dir_conf;
    type_ok_o    = 1'b0;
    if (dec_o.is_seg) begin
      unique case (kind)
        ACC_READ:  type_ok_o = dec_o.is_code ? dec_o.rd_wr : 1'b1;
        ACC_WRITE: type_ok_o = !dec_o.is_code && dec_o.rd_wr;
        ACC_EXEC:  type_ok_o = dec_o.is_code;
        default:   type_ok_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int unsigned OFS_W = 16
) (
  input  logic [OFS_W-1:0] offset_i,
  input  logic [OFS_W-1:0] limit_i,
  input  logic             expand_dn_i,
  output logic             in_range_o
);

  logic above;

  always_comb begin
    above      = offset_i > limit_i;
    in_range_o = expand_dn_i ? above : !above;
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] paddr_o
);

  localparam int unsigned PadW = ADDR_W - OFS_W;

  generate
    if (PadW > 0) begin : g_pad
      assign paddr_o = base_i + {{PadW{1'b0}}, offset_i};
    end else begin : g_trunc
      assign paddr_o = base_i + offset_i[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/seg_prot_chk.sv
module seg_prot_chk
  import seg_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        rights_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFS_W-1:0]  limit_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [1:0]        kind_i,
  input  logic [1:0]        cpl_i,
  output logic              valid_o,
  output logic              grant_o,
  output logic              fault_o,
  output logic [2:0]        fault_code_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [7:0]        rights_o
);

  rights_t           dec;
  logic              type_ok, expand_dn, conforming, in_range, priv_ok;
  logic [ADDR_W-1:0] lin_addr;
  flt_code_e         code_d;

  seg_rights_dec u_dec (
    .rights_i     (rights_i),
    .kind_i       (kind_i),
    .dec_o        (dec),
    .type_ok_o    (type_ok),
    .expand_dn_o  (expand_dn),
    .conforming_o (conforming)
  );

  seg_limit_chk #(.OFS_W(OFS_W)) u_lim (
    .offset_i    (offset_i),
    .limit_i     (limit_i),
    .expand_dn_i (expand_dn),
    .in_range_o  (in_range)
  );

  seg_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_agen (
    .base_i   (base_i),
    .offset_i (offset_i),
    .paddr_o  (lin_addr)
  );

  // priority: not present, type, limit, privilege
  always_comb begin
    priv_ok = conforming || (cpl_i <= dec.dpl);
    if      (!dec.present) code_d = FLT_NPRES;
    else if (!type_ok)     code_d = FLT_TYPE;
    else if (!in_range)    code_d = FLT_LIMIT;
    else if (!priv_ok)     code_d = FLT_PRIV;
    else                   code_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      grant_o      <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= 3'd0;
      paddr_o      <= '0;
      rights_o     <= 8'h00;
    end else begin
      valid_o <= req_i;
      grant_o <= req_i && (code_d == FLT_NONE);
      fault_o <= req_i && (code_d != FLT_NONE);
      if (req_i) begin
        fault_code_o <= code_d;
        paddr_o      <= (code_d == FLT_NONE) ? lin_addr : '0;
        rights_o     <= rights_i | {7'd0, code_d == FLT_NONE};
      end
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (grant_o != fault_o)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!grant_o && !fault_o)); // R2

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R2

  AST_NPRES_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rights_i[7]) |=> (fault_o && fault_code_o == 3'd1)); // R3

  AST_SYS_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rights_i[7] && !rights_i[4]) |=> (fault_code_o == 3'd2)); // R4

  AST_CODE_NEVER_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rights_i[3] && kind_i == 2'd1) |=> !grant_o); // R5

  AST_DATA_NEVER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rights_i[3] && kind_i == 2'd2) |=> !grant_o); // R6

  AST_CODE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (grant_o == (fault_code_o == 3'd0))); // R10

  AST_ACC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> rights_o[0]); // R12

  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (paddr_o == '0)); // R11

endmodule

// File: tb/sim_seg_prot_chk.sv
module sim_seg_prot_chk;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  rights_i = 8'h00;
  logic [23:0] base_i = '0;
  logic [15:0] limit_i = '0;
  logic [15:0] offset_i = '0;
  logic [1:0]  kind_i = 2'd0;
  logic [1:0]  cpl_i = 2'd0;
  logic        valid_o, grant_o, fault_o;
  logic [2:0]  fault_code_o;
  logic [23:0] paddr_o;
  logic [7:0]  rights_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = !clk_i;

  seg_prot_chk u0 (
    .clk_i, .rst_ni, .req_i, .rights_i, .base_i, .limit_i, .offset_i,
    .kind_i, .cpl_i, .valid_o, .grant_o, .fault_o, .fault_code_o,
    .paddr_o, .rights_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [7:0] r, input logic [1:0] k,
                                       input logic [1:0] c, input logic [15:0] o,
                                       input logic [15:0] l);
    logic tok, inr, pok, code, dc;
    code = r[3];
    dc   = r[2];
    if (!r[4] || k == 2'd3) tok = 0;
    else if (code) tok = (k == 2'd2) || (k == 2'd0 && r[1]);
    else tok = (k == 2'd0) || (k == 2'd1 && r[1]);
    inr = (!code && dc) ? (o > l) : (o <= l);
    pok = (code && dc) || (c <= r[6:5]);
    if (!r[7]) return 3'd1;
    if (!tok)  return 3'd2;
    if (!inr)  return 3'd3;
    if (!pok)  return 3'd4;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] e, input logic [7:0] r);
    case (e)
      3'd1: return "R3/R10";
      3'd2: return !r[4] ? "R4" : (r[3] ? "R5" : "R6");
      3'd3: return r[3] ? "R7" : (r[2] ? "R8" : "R7");
      3'd4: return "R9";
      default: return "R10 grant";
    endcase
  endfunction

  task automatic run_case(input logic [7:0] r, input logic [1:0] k, input logic [1:0] c,
                          input logic [23:0] b, input logic [15:0] l, input logic [15:0] o);
    logic [2:0]  e;
    logic [23:0] pa;
    string       t;
    e  = model(r, k, c, o, l);
    pa = (e == 3'd0) ? (b + {8'd0, o}) : 24'd0;
    t  = tag_of(e, r);
    @(negedge clk_i);
    req_i = 1'b1; rights_i = r; kind_i = k; cpl_i = c;
    base_i = b; limit_i = l; offset_i = o;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R2 valid/grant/fault", {valid_o, grant_o, fault_o}, {1'b1, e == 3'd0, e != 3'd0});
    chk(t, fault_code_o, e);
    chk("R11 paddr", paddr_o, pa);
    chk("R12 rights", rights_o, r | {7'd0, e == 3'd0});
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 outputs zero in and after reset
    chk("R1 in reset", {valid_o, grant_o, fault_o, fault_code_o, paddr_o, rights_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {valid_o, grant_o, fault_o, fault_code_o, paddr_o, rights_o}, 0);

    for (int r = 0; r < 256; r++) begin
      for (int k = 0; k < 4; k++) begin
        for (int c = 0; c < 4; c++) begin
          for (int s = 0; s < 3; s++) begin
            logic [15:0] lim;
            logic [23:0] bas;
            lim = 16'h0100 + 16'(r * 37);
            bas = 24'h012340 + 24'(r * 4099);
            run_case(8'(r), 2'(k), 2'(c), bas, lim, lim - 16'd1 + 16'(s));
          end
        end
      end
      // R2 no request gives an idle result
      @(negedge clk_i);
      chk("R2 idle", {valid_o, grant_o, fault_o}, 3'b000);
    end

    // boundaries
    run_case(8'h92, 2'd0, 2'd0, 24'h000000, 16'hFFFF, 16'hFFFF);   // R7 full limit grant
    run_case(8'h96, 2'd0, 2'd0, 24'h000000, 16'hFFFF, 16'hFFFF);   // R8 grows down, all refused
    run_case(8'h96, 2'd1, 2'd0, 24'h100000, 16'h0000, 16'h0001);   // R8 just above zero
    run_case(8'h96, 2'd0, 2'd0, 24'h100000, 16'h0000, 16'h0000);   // R8 at limit zero
    run_case(8'h92, 2'd1, 2'd0, 24'hFFFFF0, 16'hFFFF, 16'h0020);   // R11 wrap
    run_case(8'h9A, 2'd2, 2'd3, 24'h000100, 16'h0010, 16'h0020);   // R10 limit before priv
    run_case(8'h9E, 2'd2, 2'd3, 24'h000100, 16'h0010, 16'h0008);   // R9 conforming
    run_case(8'h1A, 2'd1, 2'd3, 24'h000100, 16'h0010, 16'h0020);   // R3 beats everything

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule